// File: doc/BRIEF.md
# Handshaked Row-Column Block Interleaver

This block spreads a stream of wide words across time so that a burst of adjacent bit errors on the output side lands in many different input words. It holds a single register array of 32 rows by 40 columns. During the fill phase each accepted 40-bit input word is stored as one row, with rows taken in ascending order. During the drain phase the array is emitted one column per cycle as a 32-bit word, so output word k carries bit k of every stored row.

A single array serves both phases. A one-cycle handover between them takes the place of a second bank. The producer watches `in_ready`, which is high only while the block is filling. Words offered while it is low are dropped. The consumer takes `out_data` whenever `out_valid` is high. After the last column is sent, the block goes back to filling, and the fill, handover and drain sequence repeats for as long as the block runs.

Top module: `rc_interleaver`

## Requirements
- R1: With `rst_n` low at a clock edge, the block clears the whole array and both counters and enters the fill phase. In the cycle after reset `in_ready` is 1 and `out_valid` is 0, and the first word accepted afterwards goes to row 0.
- R2: In the fill phase, the n-th word accepted (n counted from 0 since the phase began, a word being accepted when `in_valid` and `in_ready` are both 1 at a clock edge) is stored as row n, for n from 0 to 31.
- R3: `in_ready` is 1 only during the fill phase. A word offered while `in_ready` is 0 changes neither the array nor the row count, so none of its bits appears in a later drain.
- R4: The edge that accepts the 32nd word ends the fill phase. Exactly one cycle follows in which `in_ready` and `out_valid` are both 0, and in the cycle after that the drain begins.
- R5: The drain lasts exactly 40 consecutive cycles with `out_valid` at 1. In drain cycle k (k from 0 to 39), bit r of `out_data` equals bit k of row r.
- R6: In the cycle after drain cycle 39, `in_ready` is 1 again, `out_valid` is 0, and the next accepted word goes to row 0, overwriting the previous contents.
- R7: In the fill phase, a cycle with `in_valid` at 0 does not advance the row count. Gaps between words do not change where later words are stored.
- R8: `out_data` is all zeros in every cycle with `out_valid` at 0.
- R9: `in_ready` and `out_valid` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 40 | Word to be stored as one row |
| in_valid | input | 1 | `in_data` is offered this cycle |
| in_ready | output | 1 | Block is filling and takes an offered word |
| out_data | output | 32 | Column word, bit r from row r |
| out_valid | output | 1 | `out_data` carries a column this cycle |

## Verification
The assertions take for granted that `in_valid` and `in_data` carry known values on every clock edge after reset. They do not require the producer to respect `in_ready`, because offering a word while the block is busy is legal and must be ignored. The stimulus therefore drives defined values every cycle, including random words with `in_valid` high during the handover and the drain. It also varies the density of words during filling, from back-to-back to sparse, so the row-count hold on idle cycles is exercised under the same properties.

// File: rtl/rc_pkg.sv
// Shared definitions for the row-column interleaver.
// Assumes: one clock domain, phases advance strictly fill -> handover -> drain.
package rc_pkg;
    typedef enum logic [1:0] {
        PH_FILL  = 2'd0,
        PH_HAND  = 2'd1,
        PH_DRAIN = 2'd2
    } phase_t;
endpackage

// File: rtl/rc_phase_ctrl.sv
// Phase sequencer: counts accepted rows in the fill phase, inserts one
// handover cycle, then counts columns in the drain phase.
// Assumes: in_valid is known after reset; ROWS and COLS are at least 2.
module rc_phase_ctrl
    import rc_pkg::*;
#(
    parameter int ROWS = 32,
    parameter int COLS = 40,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          wr_en,
    output logic [RW-1:0] wr_row,
    output logic          rd_en,
    output logic [CW-1:0] rd_col
);
    localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
    localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

    phase_t        phase;
    logic [RW-1:0] wr_cnt;
    logic [CW-1:0] rd_cnt;

    // Sequence the phases and step the row and column counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_FILL;
            wr_cnt <= '0;
            rd_cnt <= '0;
        end else begin
            case (phase)
                PH_FILL: begin
                    if (in_valid) begin
                        if (wr_cnt == ROW_LAST) begin
                            wr_cnt <= '0;
                            phase  <= PH_HAND;
                        end else begin
                            wr_cnt <= wr_cnt + 1'b1;
                        end
                    end
                end
                PH_HAND: begin
                    rd_cnt <= '0;
                    phase  <= PH_DRAIN;
                end
                PH_DRAIN: begin
                    if (rd_cnt == COL_LAST) begin
                        rd_cnt <= '0;
                        phase  <= PH_FILL;
                    end else begin
                        rd_cnt <= rd_cnt + 1'b1;
                    end
                end
                default: phase <= PH_FILL;
            endcase
        end
    end

    // Decode the phase into the strobes seen by the array and the ports.
    always_comb begin
        in_ready = (phase == PH_FILL);
        wr_en    = (phase == PH_FILL) && in_valid;
        rd_en    = (phase == PH_DRAIN);
        wr_row   = wr_cnt;
        rd_col   = rd_cnt;
    end

    // R1: leaving reset lands in the fill phase with both counters cleared.
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (phase == PH_FILL && wr_cnt == '0 && rd_cnt == '0));

    // R2: every accepted word short of the last moves the row count by one.
    p_row_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FILL && in_valid && wr_cnt != ROW_LAST)
        |=> (phase == PH_FILL && wr_cnt == $past(wr_cnt) + 1'b1));

    // R4: the last accepted row is followed by the handover, then drain column 0.
    p_hand_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FILL && in_valid && wr_cnt == ROW_LAST) |=> (phase == PH_HAND));
    p_hand_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HAND) |=> (phase == PH_DRAIN && rd_cnt == '0));

    // R5: the drain walks columns one per cycle without leaving early.
    p_col_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DRAIN && rd_cnt != COL_LAST)
        |=> (phase == PH_DRAIN && rd_cnt == $past(rd_cnt) + 1'b1));

    // R6: the final column hands control back to filling from row 0.
    p_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DRAIN && rd_cnt == COL_LAST) |=> (phase == PH_FILL && wr_cnt == '0));

    // R7: an idle fill cycle leaves the row count where it was.
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FILL && !in_valid) |=> (phase == PH_FILL && $stable(wr_cnt)));
endmodule

// File: rtl/rc_row_store.sv
// Flip-flop array of ROWS words of COLS bits; one row written per enabled
// cycle, all rows visible in parallel for column extraction.
// Assumes: wr_row < ROWS whenever wr_en is high.
module rc_row_store #(
    parameter int ROWS = 32,
    parameter int COLS = 40,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [RW-1:0]              wr_row,
    input  logic [COLS-1:0]            wr_data,
    output logic [ROWS-1:0][COLS-1:0]  rows_o
);
    logic [COLS-1:0] row_q [ROWS];
    logic [ROWS-1:0] row_we;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        // Row write enable: one row selected by the fill counter.
        assign row_we[r] = wr_en && (wr_row == RW'(r));

        // Hold one row; cleared by reset, loaded when its enable is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q[r] <= '0;
            end else if (row_we[r]) begin
                row_q[r] <= wr_data;
            end
        end

        assign rows_o[r] = row_q[r];
    end

    // R2: the addressed row holds the written word on the following cycle.
    p_row_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rows_o[$past(wr_row)] == $past(wr_data)));

    // R3: without a write strobe no row of the array changes.
    p_array_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rows_o));

    // At most one row is enabled in any cycle.
    p_one_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_we));
endmodule

// File: rtl/rc_col_select.sv
// Column extraction: picks bit rd_col of every row to form a ROWS-bit word,
// and drives zeros when no column is being read.
// Assumes: rd_col < COLS whenever rd_en is high.
module rc_col_select #(
    parameter int ROWS = 32,
    parameter int COLS = 40,
    localparam int CW  = $clog2(COLS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ROWS-1:0][COLS-1:0]  rows_i,
    input  logic                       rd_en,
    input  logic [CW-1:0]              rd_col,
    output logic [ROWS-1:0]            col_o
);
    logic [COLS-1:0] col_oh;

    for (genvar c = 0; c < COLS; c++) begin : g_col
        // Column read enable: one column selected by the drain counter.
        assign col_oh[c] = rd_en && (rd_col == CW'(c));
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_bit
        // Output bit r: the selected bit of row r.
        assign col_o[r] = |(rows_i[r] & col_oh);
    end

    // R5: a drain cycle always addresses exactly one existing column.
    p_col_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> $onehot(col_oh));
endmodule

// File: rtl/rc_interleaver.sv
// Row-column block interleaver on one register array: fills ROWS words of
// COLS bits row by row, waits one handover cycle, drains COLS words of ROWS
// bits column by column, and repeats.
// Assumes: single clock; producer may offer words at any time.
module rc_interleaver #(
    parameter int ROWS = 32,
    parameter int COLS = 40,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(COLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [COLS-1:0] in_data,
    input  logic            in_valid,
    output logic            in_ready,
    output logic [ROWS-1:0] out_data,
    output logic            out_valid
);
    logic                      wr_en;
    logic [RW-1:0]             wr_row;
    logic                      rd_en;
    logic [CW-1:0]             rd_col;
    logic [ROWS-1:0][COLS-1:0] rows;

    rc_phase_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .wr_en    (wr_en),
        .wr_row   (wr_row),
        .rd_en    (rd_en),
        .rd_col   (rd_col)
    );

    rc_row_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_data (in_data),
        .rows_o  (rows)
    );

    rc_col_select #(.ROWS(ROWS), .COLS(COLS)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .rows_i (rows),
        .rd_en  (rd_en),
        .rd_col (rd_col),
        .col_o  (out_data)
    );

    assign out_valid = rd_en;

    // R9: the block never accepts and emits in the same cycle.
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R4: after the final row is taken, one cycle is silent on both sides.
    p_silent_hand_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid && wr_row == RW'(ROWS - 1)) |=> (!in_ready && !out_valid));

    // R8: the output word is quiet whenever it is not valid.
    p_quiet_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0));
endmodule

// File: tb/rc_interleaver_tb.sv
module rc_interleaver_tb;
    localparam int ROWS = 32;
    localparam int COLS = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [COLS-1:0] in_data = '0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [ROWS-1:0] out_data;
    logic            out_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state derived from the requirements.
    logic [COLS-1:0] ref_mem [ROWS];
    int ref_mode;      // 0 fill, 1 handover, 2 drain
    int ref_row;
    int ref_col;
    bit just_back;     // first fill cycle after a drain
    int rounds_done;

    always #4 clk = ~clk;

    rc_interleaver #(.ROWS(ROWS), .COLS(COLS)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [ROWS-1:0] ref_column(input int k);
        logic [ROWS-1:0] v;
        for (int r = 0; r < ROWS; r++) v[r] = ref_mem[r][k];
        return v;
    endfunction

    function automatic logic [COLS-1:0] gen_word(input int kind, input int idx);
        logic [COLS-1:0] w;
        for (int b = 0; b < COLS; b++) begin
            case (kind)
                1:       w[b] = (b == (idx % COLS));
                2:       w[b] = ((b + idx) % 2 == 0);
                3:       w[b] = ((idx % 2) == 0);
                default: w[b] = 1'($urandom % 2);
            endcase
        end
        return w;
    endfunction

    task automatic ref_reset();
        for (int r = 0; r < ROWS; r++) ref_mem[r] = '0;
        ref_mode  = 0;
        ref_row   = 0;
        ref_col   = 0;
        just_back = 1'b0;
    endtask

    // One cycle: drive at negedge, check outputs, advance reference at posedge.
    task automatic cycle(input bit v, input logic [COLS-1:0] d);
        string rq;
        in_valid = v;
        in_data  = d;
        chk(in_ready == (ref_mode == 0), (ref_mode == 0 && !v) ? "R7" : "R3",
            64'(in_ready), 64'(ref_mode == 0));
        rq = (ref_mode == 1) ? "R4" : (just_back ? "R6" : "R5");
        chk(out_valid == (ref_mode == 2), rq, 64'(out_valid), 64'(ref_mode == 2));
        if (ref_mode == 2)
            chk(out_data == ref_column(ref_col), "R2/R5", 64'(out_data),
                64'(ref_column(ref_col)));
        else
            chk(out_data == '0, "R8", 64'(out_data), 64'd0);
        chk(!(in_ready && out_valid), "R9", 64'({in_ready, out_valid}), 64'd0);
        @(posedge clk);
        just_back = 1'b0;
        case (ref_mode)
            0: if (v) begin
                ref_mem[ref_row] = d;
                ref_row++;
                if (ref_row == ROWS) begin ref_row = 0; ref_mode = 1; end
            end
            1: begin ref_mode = 2; ref_col = 0; end
            default: begin
                ref_col++;
                if (ref_col == COLS) begin
                    ref_mode = 0; ref_col = 0; just_back = 1'b1; rounds_done++;
                end
            end
        endcase
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        ref_reset();
        // R1: ready and quiet output straight after reset
        chk(in_ready == 1'b1, "R1", 64'(in_ready), 64'd1);
        chk(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
        chk(out_data == '0, "R1", 64'(out_data), 64'd0);
    endtask

    // Run until one full fill/handover/drain round completes.
    task automatic run_round(input int pct_valid, input int kind);
        int target = rounds_done + 1;
        int idx = 0;
        while (rounds_done < target) begin
            bit v = ($urandom % 100) < pct_valid;
            if (ref_mode == 0) begin
                // R7: idle cycles mixed in when pct_valid < 100
                cycle(v, v ? gen_word(kind, idx) : gen_word(0, 0));
                if (v) idx++;
            end else begin
                // R3: words offered while busy must be dropped
                cycle(v, gen_word(0, 0));
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rounds_done = 0;
        ref_reset();
        @(negedge clk);
        do_reset();
        run_round(100, 1);   // back-to-back walking one, busy-time offers
        run_round(50, 0);    // random data, sparse
        run_round(100, 2);   // checkerboard
        run_round(25, 0);    // very sparse
        // R1: mid-fill reset, then fresh round must start at row 0
        for (int i = 0; i < 10; i++) cycle(1'b1, gen_word(3, i));
        do_reset();
        run_round(100, 3);
        run_round(70, 0);
        run_round(100, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule